// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit I/O virtual address into a physical address. It reads a two-level translation table from memory. A consumer hands it one request, made of the virtual address and the byte address of the first-level table. The walker then reads one or two table words through a word read port. That port uses a valid/ready request channel and returns each response after a variable number of cycles. The walker then reports either the physical address or a fault.

The first-level entry can end the walk in one of two ways: as a fault, or as a 1 MB section. It can also point to a 1 KB aligned second-level table. A second-level entry maps a 64 KB large page or a 4 KB small page, or it faults. The two levels read the 2-bit type field differently. At the first level, pattern 11 is a fault. At the second level, any entry with bit 1 set is a small page.

Only one walk is in progress at a time. The result stays on the outputs until the consumer acknowledges it. The walker does not cache translations, check permissions or write to the table.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high. Its first read goes to `req_tbase + 4*vaddr[31:20]`, and any request offered while a walk is in progress is ignored.
- R2: A first-level entry whose bits [1:0] are 00 or 11 ends the walk after one read with `res_fault`=1, `res_level`=0 and `res_paddr`=0.
- R3: A first-level entry with bits [1:0] = 10 ends the walk after one read with `res_fault`=0, `res_level`=0 and `res_paddr` = {entry[31:20], vaddr[19:0]}.
- R4: A first-level entry with bits [1:0] = 01 causes exactly one more read. That read goes to {entry[31:10], 10'b0} + 4*vaddr[19:12], and it is issued after the first-level response.
- R5: A second-level entry whose bits [1:0] are 00 ends the walk with `res_fault`=1, `res_level`=1 and `res_paddr`=0. `res_fault_vaddr` always equals the virtual address of the accepted request.
- R6: A second-level entry with bits [1:0] = 01 yields `res_paddr` = {entry[31:16], vaddr[15:0]}, with `res_fault`=0 and `res_level`=1.
- R7: A second-level entry with bit 1 set yields `res_paddr` = {entry[31:12], vaddr[11:0]}, with `res_fault`=0 and `res_level`=1, whatever value bit 0 holds.
- R8: While `res_ready` is low, `res_valid` and all result fields stay constant. In the cycle after `res_valid` and `res_ready` are both high, `res_valid` is low and `req_ready` is high.
- R9: `mem_req_valid` stays high with a stable address until `mem_req_ready` is high. At most one read is outstanding at a time, and the result does not depend on the stall pattern or the response latency.
- R10: Reset is synchronous and active low, and it can be applied in the middle of a walk. It leaves `req_ready`=1, `mem_req_valid`=0 and `res_valid`=0, with no read outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_tbase | input | 32 | Byte address of the first-level table |
| mem_req_valid | output | 1 | Table read request present |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data present, one cycle per accepted read |
| mem_rsp_data | input | 32 | Table word read |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 32 | Physical address, zero on a fault |
| res_fault | output | 1 | Walk ended on a fault entry |
| res_fault_vaddr | output | 32 | Virtual address of the walk |
| res_level | output | 1 | Table level of the entry that ended the walk (0 first, 1 second) |

## Verification
The checker assumes the memory behaves correctly. Memory raises `mem_rsp_valid` for exactly one cycle per accepted read, and only while that read is outstanding. It never answers twice and never answers before it accepts the request. The bench's memory model follows this rule: it takes one request, counts down a programmed latency, returns a single response, and clears its own state on reset. Within that rule, the bench varies the latency and a stall pattern on `mem_req_ready`. It also holds `res_ready` low for several cycles before each acknowledge.

// File: rtl/ptw_pkg.sv
// Package: shared types for the two-level table walker.
// Assumes: the walk control state and both entry classifications are
// small enums consumed by the decoders and the top-level sequencer.
package ptw_pkg;

    // Sequencer state of one walk.
    typedef enum logic [1:0] {
        WS_IDLE    = 2'd0,
        WS_L1_WAIT = 2'd1,
        WS_L2_WAIT = 2'd2,
        WS_DONE    = 2'd3
    } walk_st_e;

    // Classification of a first-level word.
    typedef enum logic [1:0] {
        L1K_FAULT   = 2'd0,
        L1K_TABLE   = 2'd1,
        L1K_SECTION = 2'd2
    } l1_kind_e;

    // Classification of a second-level word.
    typedef enum logic [1:0] {
        L2K_FAULT = 2'd0,
        L2K_LARGE = 2'd1,
        L2K_SMALL = 2'd2
    } l2_kind_e;

    // Level tag reported with every result.
    localparam logic LVL_FIRST  = 1'b0;
    localparam logic LVL_SECOND = 1'b1;

endpackage

// File: rtl/ptw_l1_decode.sv
// Module: ptw_l1_decode
// Classifies a first-level table word and forms the section address and
// the second-level table base from it. Purely combinational.
// Assumes: the type lives in bits [1:0]; 01 = table pointer, 10 = section,
// 00 and 11 = fault. The next-table base is aligned to 2**L2_ALIGN bytes.
module ptw_l1_decode
    import ptw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int SECT_BITS = 20,
    parameter int L2_ALIGN  = 10
) (
    input  logic [AW-1:0] entry,
    input  logic [AW-1:0] vaddr,
    output l1_kind_e      kind,
    output logic [AW-1:0] sect_paddr,
    output logic [AW-1:0] l2_base
);

    // Bits that carry attributes this walker does not interpret.
    logic unused_bits;
    assign unused_bits = ^{entry[L2_ALIGN-1:2], vaddr[AW-1:SECT_BITS]};

    // Type decode: only 01 and 10 are valid first-level encodings.
    always_comb begin
        unique case (entry[1:0])
            2'b01:   kind = L1K_TABLE;
            2'b10:   kind = L1K_SECTION;
            default: kind = L1K_FAULT;
        endcase
    end

    // Section frame joined with the in-section offset.
    assign sect_paddr = {entry[AW-1:SECT_BITS], vaddr[SECT_BITS-1:0]};

    // Aligned base of the second-level table.
    assign l2_base = {entry[AW-1:L2_ALIGN], {L2_ALIGN{1'b0}}};

endmodule

// File: rtl/ptw_l2_decode.sv
// Module: ptw_l2_decode
// Classifies a second-level table word and forms the physical address
// for a large or small page. Purely combinational.
// Assumes: bit 1 set marks a small page regardless of bit 0; 01 marks a
// large page; 00 is a fault. A fault yields a zero address.
module ptw_l2_decode
    import ptw_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LPAGE_BITS = 16,
    parameter int SPAGE_BITS = 12
) (
    input  logic [AW-1:0] entry,
    input  logic [AW-1:0] vaddr,
    output l2_kind_e      kind,
    output logic [AW-1:0] paddr
);

    // Bits outside any field used here.
    logic unused_bits;
    assign unused_bits = ^{entry[SPAGE_BITS-1:2], vaddr[AW-1:LPAGE_BITS]};

    logic [AW-1:0] large_pa;
    logic [AW-1:0] small_pa;

    // Frame-plus-offset candidates for both page sizes.
    assign large_pa = {entry[AW-1:LPAGE_BITS], vaddr[LPAGE_BITS-1:0]};
    assign small_pa = {entry[AW-1:SPAGE_BITS], vaddr[SPAGE_BITS-1:0]};

    // Type decode: bit 1 has priority over bit 0.
    always_comb begin
        if (entry[1]) begin
            kind = L2K_SMALL;
        end else if (entry[0]) begin
            kind = L2K_LARGE;
        end else begin
            kind = L2K_FAULT;
        end
    end

    // Address select by decoded kind.
    always_comb begin
        unique case (kind)
            L2K_SMALL: paddr = small_pa;
            L2K_LARGE: paddr = large_pa;
            default:   paddr = '0;
        endcase
    end

endmodule

// File: rtl/ptw_read_port.sv
// Module: ptw_read_port
// Issues single word reads on a valid/ready request channel and tracks
// the response of a variable-latency memory.
// Assumes: `issue` pulses only when no read is pending; memory returns
// exactly one single-cycle response for each accepted request.
module ptw_read_port #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [AW-1:0] issue_addr,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    output logic          rsp_fire
);

    logic          pend_req;
    logic          pend_rsp;
    logic [AW-1:0] addr_q;

    // Request phase and response phase bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_req <= 1'b0;
            pend_rsp <= 1'b0;
            addr_q   <= '0;
        end else begin
            if (issue) begin
                pend_req <= 1'b1;
                addr_q   <= issue_addr;
            end else if (pend_req && mem_req_ready) begin
                pend_req <= 1'b0;
                pend_rsp <= 1'b1;
            end
            if (rsp_fire) begin
                pend_rsp <= 1'b0;
            end
        end
    end

    // Response is taken only while one is awaited.
    assign rsp_fire      = pend_rsp && mem_rsp_valid;
    assign mem_req_valid = pend_req;
    assign mem_req_addr  = addr_q;

endmodule

// File: rtl/ptw_walker.sv
// Module: ptw_walker (top)
// Walks a two-level translation table for one virtual address at a time:
// a first-level read, optionally a second-level read, then a held result.
// Assumes: word entries of AW bits, byte addressing, entry address =
// table base + 4 * index; consumer acknowledges with res_ready.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SECT_BITS  = 20,
    parameter int LPAGE_BITS = 16,
    parameter int SPAGE_BITS = 12,
    parameter int L2_ALIGN   = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    input  logic [AW-1:0] req_tbase,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data,
    output logic          res_valid,
    input  logic          res_ready,
    output logic [AW-1:0] res_paddr,
    output logic          res_fault,
    output logic [AW-1:0] res_fault_vaddr,
    output logic          res_level
);

    localparam int L1_IDX_W    = AW - SECT_BITS;
    localparam int L2_IDX_W    = SECT_BITS - SPAGE_BITS;
    localparam int ENTRY_SHIFT = 2;

    walk_st_e      st;
    logic [AW-1:0] va_q;
    logic [AW-1:0] paddr_q;
    logic          fault_q;
    logic          lvl_q;

    logic          issue;
    logic [AW-1:0] issue_addr;
    logic          rsp_fire;

    l1_kind_e      l1_kind;
    logic [AW-1:0] l1_sect_pa;
    logic [AW-1:0] l2_base;
    l2_kind_e      l2_kind;
    logic [AW-1:0] l2_pa;

    logic [AW-1:0] l1_off;
    logic [AW-1:0] l2_off;

    // Byte offsets of the indexed entries in each table.
    assign l1_off = AW'({req_vaddr[AW-1:SECT_BITS], {ENTRY_SHIFT{1'b0}}});
    assign l2_off = AW'({va_q[SECT_BITS-1:SPAGE_BITS], {ENTRY_SHIFT{1'b0}}});

    ptw_l1_decode #(
        .AW        (AW),
        .SECT_BITS (SECT_BITS),
        .L2_ALIGN  (L2_ALIGN)
    ) u_l1_dec (
        .entry      (mem_rsp_data),
        .vaddr      (va_q),
        .kind       (l1_kind),
        .sect_paddr (l1_sect_pa),
        .l2_base    (l2_base)
    );

    ptw_l2_decode #(
        .AW         (AW),
        .LPAGE_BITS (LPAGE_BITS),
        .SPAGE_BITS (SPAGE_BITS)
    ) u_l2_dec (
        .entry (mem_rsp_data),
        .vaddr (va_q),
        .kind  (l2_kind),
        .paddr (l2_pa)
    );

    ptw_read_port #(
        .AW (AW)
    ) u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue         (issue),
        .issue_addr    (issue_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_fire      (rsp_fire)
    );

    // Read launch: first level on acceptance, second level on a table pointer.
    always_comb begin
        issue      = 1'b0;
        issue_addr = l2_base + l2_off;
        if (st == WS_IDLE) begin
            issue      = req_valid;
            issue_addr = req_tbase + l1_off;
        end else if (st == WS_L1_WAIT && rsp_fire && l1_kind == L1K_TABLE) begin
            issue = 1'b1;
        end
    end

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= WS_IDLE;
            va_q    <= '0;
            paddr_q <= '0;
            fault_q <= 1'b0;
            lvl_q   <= LVL_FIRST;
        end else begin
            unique case (st)
                WS_IDLE: begin
                    if (req_valid) begin
                        va_q <= req_vaddr;
                        st   <= WS_L1_WAIT;
                    end
                end
                WS_L1_WAIT: begin
                    if (rsp_fire) begin
                        unique case (l1_kind)
                            L1K_SECTION: begin
                                fault_q <= 1'b0;
                                paddr_q <= l1_sect_pa;
                                lvl_q   <= LVL_FIRST;
                                st      <= WS_DONE;
                            end
                            L1K_TABLE: begin
                                st <= WS_L2_WAIT;
                            end
                            default: begin
                                fault_q <= 1'b1;
                                paddr_q <= '0;
                                lvl_q   <= LVL_FIRST;
                                st      <= WS_DONE;
                            end
                        endcase
                    end
                end
                WS_L2_WAIT: begin
                    if (rsp_fire) begin
                        fault_q <= (l2_kind == L2K_FAULT);
                        paddr_q <= l2_pa;
                        lvl_q   <= LVL_SECOND;
                        st      <= WS_DONE;
                    end
                end
                default: begin
                    if (res_ready) begin
                        st <= WS_IDLE;
                    end
                end
            endcase
        end
    end

    // Handshake and result outputs.
    assign req_ready       = (st == WS_IDLE);
    assign res_valid       = (st == WS_DONE);
    assign res_paddr       = paddr_q;
    assign res_fault       = fault_q;
    assign res_fault_vaddr = va_q;
    assign res_level       = lvl_q;

    // Index widths documented for the derived offsets above.
    localparam int IDX_SUM = L1_IDX_W + L2_IDX_W;
    initial begin
        if (IDX_SUM != AW - SPAGE_BITS) begin
            $error("ptw_walker: inconsistent index widths");
        end
    end

endmodule

// File: rtl/ptw_walker_chk.sv
// Module: ptw_walker_chk
// Property checker for ptw_walker, attached by bind below.
// Assumes: memory answers once per accepted read, only while it is awaited.
module ptw_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr,
    input logic          mem_rsp_valid,
    input logic          res_valid,
    input logic          res_ready,
    input logic [AW-1:0] res_paddr,
    input logic          res_fault,
    input logic [AW-1:0] res_fault_vaddr,
    input logic          res_level
);

    logic [1:0] out_q;
    logic [1:0] walk_reads;
    logic       rd_fire;

    assign rd_fire = mem_req_valid && mem_req_ready;

    // Outstanding reads and reads issued in the current walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q      <= 2'd0;
            walk_reads <= 2'd0;
        end else begin
            out_q <= out_q + {1'b0, rd_fire} - {1'b0, mem_rsp_valid};
            if (req_valid && req_ready) begin
                walk_reads <= 2'd0;
            end else if (rd_fire && walk_reads != 2'd3) begin
                walk_reads <= walk_reads + 2'd1;
            end
        end
    end

    p_idle_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!res_valid && !mem_req_valid && out_q == 2'd0));

    p_l1_end_one_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_level) |-> (walk_reads == 2'd1));

    p_fault_zero_pa_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_paddr == '0));

    p_l2_end_two_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_level) |-> (walk_reads == 2'd2));

    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr) &&
            $stable(res_fault) && $stable(res_fault_vaddr) && $stable(res_level)));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready) |=> (!res_valid && req_ready));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_single_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != 2'd0) |-> !mem_req_valid);

    p_rsp_expected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (out_q == 2'd1));

    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !mem_req_valid && !res_valid));

endmodule

bind ptw_walker ptw_walker_chk #(.AW(AW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .mem_rsp_valid   (mem_rsp_valid),
    .res_valid       (res_valid),
    .res_ready       (res_ready),
    .res_paddr       (res_paddr),
    .res_fault       (res_fault),
    .res_fault_vaddr (res_fault_vaddr),
    .res_level       (res_level)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
// Directed bench for ptw_walker with a latency- and stall-programmable memory.
module ptw_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_tbase = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [31:0] res_paddr;
    logic        res_fault;
    logic [31:0] res_fault_vaddr;
    logic        res_level;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    ptw_walker u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_vaddr       (req_vaddr),
        .req_tbase       (req_tbase),
        .mem_req_valid   (mem_req_valid),
        .mem_req_ready   (mem_req_ready),
        .mem_req_addr    (mem_req_addr),
        .mem_rsp_valid   (mem_rsp_valid),
        .mem_rsp_data    (mem_rsp_data),
        .res_valid       (res_valid),
        .res_ready       (res_ready),
        .res_paddr       (res_paddr),
        .res_fault       (res_fault),
        .res_fault_vaddr (res_fault_vaddr),
        .res_level       (res_level)
    );

    // ---------------- memory model ----------------
    logic [31:0] tbl [logic [31:0]];
    logic [31:0] rd_log [0:15];
    int          rd_total = 0;
    int          lat_cfg = 0;
    bit          stall_cfg = 1'b0;
    int          cyc = 0;
    bit          mem_busy = 1'b0;
    int          wait_cnt = 0;
    logic [31:0] pend_addr = '0;

    function automatic logic [31:0] mem_lookup(input logic [31:0] a);
        return tbl.exists(a) ? tbl[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_busy      <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_req_ready <= 1'b0;
        end else begin
            mem_rsp_valid <= 1'b0;
            mem_req_ready <= stall_cfg ? ((cyc % 3) == 2) : 1'b1;
            if (mem_busy) begin
                if (wait_cnt == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= mem_lookup(pend_addr);
                    mem_busy      <= 1'b0;
                end else begin
                    wait_cnt <= wait_cnt - 1;
                end
            end
            if (mem_req_valid && mem_req_ready) begin
                mem_busy                <= 1'b1;
                pend_addr               <= mem_req_addr;
                wait_cnt                <= lat_cfg;
                rd_log[rd_total % 16]   <= mem_req_addr;
                rd_total                <= rd_total + 1;
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // One full walk: launch, wait for the result, check it, check the hold,
    // acknowledge and check the release (R1, R8 plus the scenario's tag).
    task automatic run_walk(input string rq, input logic [31:0] va,
                            input logic [31:0] tb, input bit exp_f,
                            input logic [31:0] exp_pa, input bit exp_lvl,
                            input int exp_n, input logic [31:0] a0,
                            input logic [31:0] a1, input bit junk);
        int n0;
        logic [31:0] pa_seen;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        n0 = rd_total;
        req_valid = 1'b1;
        req_vaddr = va;
        req_tbase = tb;
        @(negedge clk);
        if (junk) begin
            // R1: a second request offered mid-walk must be ignored
            req_vaddr = 32'hDEAD_BEEF;
            req_tbase = 32'h0F00_0000;
        end else begin
            req_valid = 1'b0;
        end
        chk("R1", "req_ready during walk", {31'b0, req_ready}, 32'd0);
        while (!res_valid) @(negedge clk);
        req_valid = 1'b0;
        chk(rq, "fault", {31'b0, res_fault}, {31'b0, exp_f});
        chk(rq, "paddr", res_paddr, exp_pa);
        chk(rq, "level", {31'b0, res_level}, {31'b0, exp_lvl});
        chk("R5", "fault vaddr", res_fault_vaddr, va);
        chk(rq, "read count", rd_total - n0, exp_n);
        chk("R1", "first read address", rd_log[n0 % 16], a0);
        if (exp_n == 2) begin
            chk("R4", "second read address", rd_log[(n0 + 1) % 16], a1);
        end
        pa_seen = res_paddr;
        repeat (3) @(negedge clk);
        chk("R8", "valid held", {31'b0, res_valid}, 32'd1);
        chk("R8", "paddr held", res_paddr, pa_seen);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk("R8", "valid released", {31'b0, res_valid}, 32'd0);
        chk("R8", "ready restored", {31'b0, req_ready}, 32'd1);
    endtask

    localparam logic [31:0] TB0 = 32'h0010_0000;

    // Scenario: reset state (R10).
    task automatic t_reset();
        chk("R10", "req_ready", {31'b0, req_ready}, 32'd1);
        chk("R10", "mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
        chk("R10", "res_valid", {31'b0, res_valid}, 32'd0);
    endtask

    // Scenario: sections, including the last first-level index (R3).
    task automatic t_section();
        tbl[TB0 + 32'h48C] = 32'hABC0_0002;
        run_walk("R3", 32'h1234_5678, TB0, 1'b0, 32'hABC4_5678, 1'b0, 1,
                 TB0 + 32'h48C, 32'h0, 1'b0);
        tbl[TB0 + 32'h3FFC] = 32'hFFF0_0002;
        run_walk("R3", 32'hFFFA_BCDE, TB0, 1'b0, 32'hFFFA_BCDE, 1'b0, 1,
                 TB0 + 32'h3FFC, 32'h0, 1'b0);
    endtask

    // Scenario: first-level faults with types 00 and 11 (R2).
    task automatic t_l1_fault();
        run_walk("R2", 32'h0005_0000, TB0, 1'b1, 32'h0, 1'b0, 1,
                 TB0 + 32'h000, 32'h0, 1'b0);
        tbl[TB0 + 32'h018] = 32'h7770_0003;
        run_walk("R2", 32'h0060_1000, TB0, 1'b1, 32'h0, 1'b0, 1,
                 TB0 + 32'h018, 32'h0, 1'b0);
    endtask

    // Scenario: second-level pages and fault (R4, R6, R7, R5).
    task automatic t_pages();
        tbl[TB0 + 32'h0D0]     = 32'h0020_0401;
        tbl[32'h0020_05E0]     = 32'h5555_0001;
        tbl[32'h0020_0604]     = 32'h9876_5002;
        tbl[32'h0020_0608]     = 32'h1357_9003;
        run_walk("R6", 32'h0347_89AB, TB0, 1'b0, 32'h5555_89AB, 1'b1, 2,
                 TB0 + 32'h0D0, 32'h0020_05E0, 1'b0);
        run_walk("R7", 32'h0348_1FFF, TB0, 1'b0, 32'h9876_5FFF, 1'b1, 2,
                 TB0 + 32'h0D0, 32'h0020_0604, 1'b0);
        run_walk("R7", 32'h0348_2ABC, TB0, 1'b0, 32'h1357_9ABC, 1'b1, 2,
                 TB0 + 32'h0D0, 32'h0020_0608, 1'b0);
        run_walk("R5", 32'h0348_3000, TB0, 1'b1, 32'h0, 1'b1, 2,
                 TB0 + 32'h0D0, 32'h0020_060C, 1'b0);
    endtask

    // Scenario: stalls, long latency and a request offered mid-walk (R9, R1).
    task automatic t_stall();
        stall_cfg = 1'b1;
        lat_cfg   = 5;
        run_walk("R9", 32'h0347_89AB, TB0, 1'b0, 32'h5555_89AB, 1'b1, 2,
                 TB0 + 32'h0D0, 32'h0020_05E0, 1'b1);
        stall_cfg = 1'b0;
        lat_cfg   = 2;
        run_walk("R9", 32'h1234_0001, TB0, 1'b0, 32'hABC4_0001, 1'b0, 1,
                 TB0 + 32'h48C, 32'h0, 1'b1);
        lat_cfg = 0;
    endtask

    // Scenario: reset in the middle of a walk, then a clean walk (R10).
    task automatic t_mid_reset();
        lat_cfg = 20;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = 32'h0347_89AB;
        req_tbase = TB0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10", "mid-walk reset req_ready", {31'b0, req_ready}, 32'd1);
        chk("R10", "mid-walk reset mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
        chk("R10", "mid-walk reset res_valid", {31'b0, res_valid}, 32'd0);
        lat_cfg = 1;
        rst_n = 1'b1;
        run_walk("R10", 32'h0348_1FFF, TB0, 1'b0, 32'h9876_5FFF, 1'b1, 2,
                 TB0 + 32'h0D0, 32'h0020_0604, 1'b0);
        lat_cfg = 0;
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_section();
        t_l1_fault();
        t_pages();
        t_stall();
        t_mid_reset();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule